// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block produces one interrupt per side of a shared two-port memory. The two highest words of the memory serve as mailboxes. The very top word belongs to the right side, and the word just below it belongs to the left side. When one side writes into the other side's mailbox, an interrupt is raised toward the owner of that mailbox. When the owner reads its own mailbox, its interrupt is dropped. Only the two flags and their decode are built here. The memory words and the message contents sit elsewhere.

Each side presents a select, a write strobe, an output enable, an address and a busy input from the contention arbiter. All of these are sampled on one clock. While busy is high toward a side, that side's mailbox accesses cannot raise the peer's interrupt and cannot drop its own interrupt. Each interrupt output is active low and is driven straight from a flag register. An access that is sampled at a rising edge therefore shows on the outputs just after that same edge.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no further access, both `l_irq_n` and `r_irq_n` are 1.
- R2: The right flag is raised if, at a rising edge, the left side has `l_sel`=1, `l_wr`=1, `l_busy`=0 and `l_addr` = all ones. After that edge `r_irq_n` reads 0.
- R3: The left flag is raised if, at a rising edge, the right side has `r_sel`=1, `r_wr`=1, `r_busy`=0 and `r_addr` = all ones minus one. After that edge `l_irq_n` reads 0.
- R4: A side drops its own flag with a read of its own mailbox, meaning sel=1, wr=0, oe=1, busy=0, and the address equal to its own mailbox. After that edge its irq_n reads 1.
- R5: A read of the own mailbox with oe=0 leaves the flag unchanged.
- R6: A read by a side of the other side's mailbox changes neither flag.
- R7: A mailbox write from a side whose busy input is 1 does not raise the peer's flag.
- R8: A read of the own mailbox by a side whose busy input is 1 does not drop its flag.
- R9: If one flag is raised and dropped at the same edge, it ends up raised.
- R10: The flags are unchanged by writes to a side's own mailbox, by accesses to any address other than the two mailboxes, and by accesses with sel=0.
- R11: A raised flag stays raised until its owner performs a clearing read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left side memory select, active high |
| l_wr | input | 1 | Left side write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left side output enable, active high |
| l_busy | input | 1 | Arbiter busy toward the left side, active high |
| l_addr | input | ADDR_W | Left side word address |
| r_sel | input | 1 | Right side memory select, active high |
| r_wr | input | 1 | Right side write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right side output enable, active high |
| r_busy | input | 1 | Arbiter busy toward the right side, active high |
| r_addr | input | ADDR_W | Right side word address |
| l_irq_n | output | 1 | Interrupt to the left side, active low |
| r_irq_n | output | 1 | Interrupt to the right side, active low |

## Verification
Directed sequences walk both flags through the main cases: raise, hold, clear, clear blocked by busy, a read without oe, a read of the peer's box, and a raise on the same edge as a clear. Each sequence tells the correct mailbox decode apart from one that has its two mailbox addresses swapped, or that ignores the busy input or the output enable. Random traffic afterwards is biased toward the two mailbox addresses and toward coincident accesses from both sides. It separates set-over-clear priority from the reverse priority, and it exposes a flag that responds to a near-miss address or to a deselected side.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic {
      SIDE_L = 1'b0,
      SIDE_R = 1'b1
   } mbx_side_e;

   typedef struct packed {
      logic peer_set;
      logic own_clr;
   } mbx_evt_t;

   localparam int unsigned MBX_NSIDE = 2;

endpackage

// File: rtl/mbx_addr_match.sv
module mbx_addr_match
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter mbx_side_e   SIDE   = SIDE_L
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_own,
   output logic              hit_peer
);

   localparam logic [ADDR_W-1:0] BOX_TOP  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] BOX_NEXT = BOX_TOP - 1'b1;

   generate
      if (SIDE == SIDE_R) begin : g_right
         assign hit_own  = (addr == BOX_TOP);
         assign hit_peer = (addr == BOX_NEXT);
      end else begin : g_left
         assign hit_own  = (addr == BOX_NEXT);
         assign hit_peer = (addr == BOX_TOP);
      end
   endgenerate

endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter mbx_side_e   SIDE   = SIDE_L
) (
   input  logic              sel,
   input  logic              wr,
   input  logic              oe,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   output mbx_evt_t          evt
);

   logic hit_own;
   logic hit_peer;
   logic granted;

   mbx_addr_match #(
      .ADDR_W (ADDR_W),
      .SIDE   (SIDE)
   ) u_match (
      .addr     (addr),
      .hit_own  (hit_own),
      .hit_peer (hit_peer)
   );

   assign granted = sel & ~busy;

   always_comb begin
      evt          = '0;
      evt.peer_set = granted & wr & hit_peer;
      evt.own_clr  = granted & ~wr & oe & hit_own;
   end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic irq_n
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_req) begin
         flag_q <= 1'b1;
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end

   assign irq_n = ~flag_q;

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic              l_busy,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_sel,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic              r_busy,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_irq_n,
   output logic              r_irq_n
);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mbx_irq_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   logic [MBX_NSIDE-1:0] sel_v;
   logic [MBX_NSIDE-1:0] wr_v;
   logic [MBX_NSIDE-1:0] oe_v;
   logic [MBX_NSIDE-1:0] busy_v;
   logic [ADDR_W-1:0]    addr_v [MBX_NSIDE];
   mbx_evt_t             evt_v  [MBX_NSIDE];
   logic [MBX_NSIDE-1:0] irq_n_v;

   assign sel_v  = {r_sel,  l_sel};
   assign wr_v   = {r_wr,   l_wr};
   assign oe_v   = {r_oe,   l_oe};
   assign busy_v = {r_busy, l_busy};
   assign addr_v[SIDE_L] = l_addr;
   assign addr_v[SIDE_R] = r_addr;

   generate
      for (genvar s = 0; s < MBX_NSIDE; s++) begin : g_side
         localparam mbx_side_e THIS_SIDE = mbx_side_e'(s);
         localparam int unsigned PEER    = MBX_NSIDE - 1 - s;

         mbx_port_decode #(
            .ADDR_W (ADDR_W),
            .SIDE   (THIS_SIDE)
         ) u_dec (
            .sel  (sel_v[s]),
            .wr   (wr_v[s]),
            .oe   (oe_v[s]),
            .busy (busy_v[s]),
            .addr (addr_v[s]),
            .evt  (evt_v[s])
         );

         mbx_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (evt_v[PEER].peer_set),
            .clr_req (evt_v[s].own_clr),
            .irq_n   (irq_n_v[s])
         );
      end
   endgenerate

   assign l_irq_n = irq_n_v[SIDE_L];
   assign r_irq_n = irq_n_v[SIDE_R];

endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_sel,
   input logic              l_wr,
   input logic              l_oe,
   input logic              l_busy,
   input logic [ADDR_W-1:0] l_addr,
   input logic              r_sel,
   input logic              r_wr,
   input logic              r_oe,
   input logic              r_busy,
   input logic [ADDR_W-1:0] r_addr,
   input logic              l_irq_n,
   input logic              r_irq_n
);

   localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] NEXT = TOP - 1'b1;

   logic l_puts_r, r_puts_l, l_reads_own, r_reads_own;
   assign l_puts_r    = l_sel && l_wr && !l_busy && (l_addr == TOP);
   assign r_puts_l    = r_sel && r_wr && !r_busy && (r_addr == NEXT);
   assign l_reads_own = l_sel && !l_wr && l_oe && !l_busy && (l_addr == NEXT);
   assign r_reads_own = r_sel && !r_wr && r_oe && !r_busy && (r_addr == TOP);

   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |-> (l_irq_n && r_irq_n));

   a_r2_left_raises_right: assert property (@(posedge clk) disable iff (!rst_n)
      l_puts_r |=> !r_irq_n);

   a_r3_right_raises_left: assert property (@(posedge clk) disable iff (!rst_n)
      r_puts_l |=> !l_irq_n);

   a_r4_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (r_reads_own && !l_puts_r) |=> r_irq_n);

   a_r4_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (l_reads_own && !r_puts_l) |=> l_irq_n);

   a_r7_right_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(r_irq_n) |-> $past(l_puts_r));

   a_r7_left_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(l_irq_n) |-> $past(r_puts_l));

   a_r8_busy_holds_right: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_irq_n && r_busy) |=> !r_irq_n);

   a_r8_busy_holds_left: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_irq_n && l_busy) |=> !l_irq_n);

   a_r11_right_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!r_irq_n && !(r_sel && !r_wr && r_oe && r_addr == TOP)) |=> !r_irq_n);

   a_r11_left_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_irq_n && !(l_sel && !l_wr && l_oe && l_addr == NEXT)) |=> !l_irq_n);

endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .l_sel   (l_sel),
   .l_wr    (l_wr),
   .l_oe    (l_oe),
   .l_busy  (l_busy),
   .l_addr  (l_addr),
   .r_sel   (r_sel),
   .r_wr    (r_wr),
   .r_oe    (r_oe),
   .r_busy  (r_busy),
   .r_addr  (r_addr),
   .l_irq_n (l_irq_n),
   .r_irq_n (r_irq_n)
);

// File: tb/mbx_irq_ctrl_test.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_test;

   localparam int unsigned ADDR_W = 12;
   localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] NEXT = TOP - 1'b1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sel = 0, l_wr = 0, l_oe = 0, l_busy = 0;
   logic r_sel = 0, r_wr = 0, r_oe = 0, r_busy = 0;
   logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
   logic l_irq_n, r_irq_n;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   logic exp_l = 1'b0;
   logic exp_r = 1'b0;

   always #2 clk = ~clk;

   mbx_irq_ctrl #(.ADDR_W(ADDR_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_busy(l_busy), .l_addr(l_addr),
      .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_busy(r_busy), .r_addr(r_addr),
      .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
   );

   function automatic logic next_flag(logic cur, logic set, logic clr);
      if (set) return 1'b1;
      if (clr) return 1'b0;
      return cur;
   endfunction

   function automatic logic is_write_to(logic s, logic w, logic b,
                                        logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] box);
      return s && w && !b && (a == box);
   endfunction

   function automatic logic is_read_of(logic s, logic w, logic o, logic b,
                                       logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] box);
      return s && !w && o && !b && (a == box);
   endfunction

   task automatic check(input logic act, input logic exp, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", what, act, exp);
      end
   endtask

   task automatic check_both(input string what);
      check(l_irq_n, ~exp_l, {what, " l_irq_n"});
      check(r_irq_n, ~exp_r, {what, " r_irq_n"});
   endtask

   task automatic step(input logic ls, lw, lo, lb, input logic [ADDR_W-1:0] la,
                       input logic rs, rw, ro, rb, input logic [ADDR_W-1:0] ra,
                       input string what);
      @(negedge clk);
      l_sel = ls; l_wr = lw; l_oe = lo; l_busy = lb; l_addr = la;
      r_sel = rs; r_wr = rw; r_oe = ro; r_busy = rb; r_addr = ra;
      @(posedge clk);
      exp_r = next_flag(exp_r, is_write_to(ls, lw, lb, la, TOP),
                        is_read_of(rs, rw, ro, rb, ra, TOP));
      exp_l = next_flag(exp_l, is_write_to(rs, rw, rb, ra, NEXT),
                        is_read_of(ls, lw, lo, lb, la, NEXT));
      #1;
      check_both(what);
   endtask

   task automatic idle(input string what);
      step(0, 0, 0, 0, '0, 0, 0, 0, 0, '0, what);
   endtask

   function automatic logic [ADDR_W-1:0] pick_addr();
      int unsigned k = $urandom_range(0, 9);
      if (k < 4) return TOP;
      if (k < 8) return NEXT;
      if (k == 8) return TOP - 2;
      return ADDR_W'($urandom);
   endfunction

   initial begin
      #400000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check_both("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1 after release");

      step(1, 1, 0, 0, TOP,  0, 0, 0, 0, '0, "R2 left writes right box");
      idle("R11 hold");
      idle("R11 hold again");
      step(1, 0, 1, 0, TOP,  0, 0, 0, 0, '0, "R6 left reads right box");
      step(0, 0, 0, 0, '0,   1, 0, 0, 0, TOP, "R5 right read without oe");
      step(0, 0, 0, 0, '0,   1, 0, 1, 1, TOP, "R8 right read while busy");
      step(0, 0, 0, 0, '0,   0, 0, 1, 0, TOP, "R10 right deselected read");
      step(0, 0, 0, 0, '0,   1, 0, 1, 0, TOP, "R4 right clears own");
      step(1, 1, 0, 1, TOP,  0, 0, 0, 0, '0, "R7 left write while busy");
      step(0, 0, 0, 0, '0,   1, 1, 0, 0, NEXT, "R3 right writes left box");
      step(0, 0, 0, 0, '0,   1, 0, 1, 0, NEXT, "R6 right reads left box");
      step(1, 0, 1, 0, NEXT, 1, 1, 0, 0, NEXT, "R9 set wins over clear");
      step(1, 0, 1, 0, NEXT, 0, 0, 0, 0, '0, "R4 left clears own");
      step(1, 1, 0, 0, NEXT, 1, 1, 0, 0, TOP, "R10 writes to own boxes");
      step(1, 1, 0, 0, TOP-2, 1, 1, 0, 0, TOP-2, "R10 other address");
      step(1, 1, 0, 0, TOP,  1, 0, 1, 0, TOP, "R9 right set and clear");
      step(0, 0, 0, 0, '0,   1, 1, 0, 1, NEXT, "R7 right write while busy");

      for (int i = 0; i < 3000; i++) begin
         step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
              $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0, pick_addr(),
              $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
              $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0, pick_addr(),
              "random R2 R3 R4 R7 R8 R9");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule